// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block scans a liquid-crystal panel that has four common lines and thirty-four segment lines at one-quarter duty with half bias. The segment pattern comes from a small display store of 4-bit words. A host writes and reads that store through a plain address/data port. The 8-bit address is split into a page nibble (upper four bits) and an index nibble (lower four bits). The panel refreshes from the store continuously with no host involvement.

The segment words are spread across pages. Page 8 holds the even segments and page 9 holds the odd segments, with the index selecting the segment pair. Two more pages each hold one word, at index 0, for the last two segments.

Inside each word, bit k gives the segment's state while common k is active. Every drive line is produced as a 2-bit level code, which an external bias ladder turns into a voltage. A phase strobe from a divider tap steps the active common. After each complete four-phase frame the rail polarity flips, so each pixel sees no net DC. A blank input parks every line at ground.

Top module: `lcd_scan_drv`

## Requirements
- R1: After reset the store reads zero everywhere, the phase is 0 and the polarity is positive. As a result common 0 drives supply (2'b10), commons 1 to 3 drive half level (2'b01), and every segment drives supply (2'b10).
- R2: A write to page 8 (address bits [7:4] = 4'h8) at index n (bits [3:0]) stores the segment 2n word. A read of that address returns the stored word on the next cycle and after.
- R3: A write to page 9 at index n stores the segment 2n+1 word, and a read of that address returns it.
- R4: Address 8'hA0 holds the segment 32 word and address 8'hB0 holds the segment 33 word.
- R5: A write to any address that maps to no segment changes neither the store nor any drive level. A read of such an address returns 4'h0.
- R6: Common k occupies com_lvl[2k+1:2k]. Level codes are 2'b00 ground, 2'b01 half, 2'b10 supply, and 2'b11 never appears. When not blanked, the active common drives supply in a positive frame and ground in an inverted frame, and every other common drives 2'b01.
- R7: Segment s occupies seg_lvl[2s+1:2s]. When not blanked, a segment whose word has bit p set, where p is the active phase, drives the rail opposite the active common. With the bit clear it drives the same rail as the active common.
- R8: The phase advances by one on each clock where phase_strobe is high and holds otherwise. It goes 0,1,2,3 and then wraps back to 0.
- R9: The polarity flips each time the phase wraps from 3 to 0, so the frames alternate positive and inverted.
- R10: While blank is high, every common and segment level is 2'b00. The store contents are kept, and the normal drive returns as soon as blank falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the display store |
| addr | input | 8 | Page nibble [7:4], index nibble [3:0] |
| wdata | input | 4 | Write data word |
| rdata | output | 4 | Read data for addr (combinational) |
| phase_strobe | input | 1 | One-clock pulse from a divider tap that steps the phase |
| blank | input | 1 | Forces all lines to ground |
| com_lvl | output | 8 | Common level codes, 2 bits per common |
| seg_lvl | output | 68 | Segment level codes, 2 bits per segment |

## Verification
The checker assumes that phase_strobe and blank are synchronous to clk. It also assumes that addr is stable whenever rdata is sampled, because the read path is combinational and follows addr within the same cycle. The stimulus changes every input just after a rising edge and samples on the falling edge. It issues phase strobes as single-cycle pulses separated by idle cycles, and it applies blank only between strobes.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
   localparam int LVL_W = 2;
   localparam logic [LVL_W-1:0] LVL_GND = 2'b00;
   localparam logic [LVL_W-1:0] LVL_MID = 2'b01;
   localparam logic [LVL_W-1:0] LVL_SUP = 2'b10;
   localparam int PAIR_SEGS = 32;

   // Address of the word that holds segment s.
   function automatic logic [7:0] seg_addr(input int s);
      if (s < PAIR_SEGS)
         return 8'(8'h80 + 16 * (s % 2) + s / 2);
      else
         return 8'(8'hA0 + 16 * (s - PAIR_SEGS));
   endfunction
endpackage

// File: rtl/lcd_disp_mem.sv
module lcd_disp_mem
   import lcd_drv_pkg::*;
#(
   parameter int NUM_SEG = 34,
   parameter int DW      = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [7:0]              addr,
   input  logic [DW-1:0]           wdata,
   output logic [DW-1:0]           rdata,
   output logic [NUM_SEG*DW-1:0]   seg_bits
);
   logic [NUM_SEG-1:0] hit;

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_word
      localparam logic [7:0] WORD_ADDR = seg_addr(s);
      logic [DW-1:0] word_q;

      assign hit[s] = (addr == WORD_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (wr_en && hit[s])
            word_q <= wdata;
      end

      assign seg_bits[s*DW +: DW] = word_q;
   end

   always_comb begin
      rdata = '0;
      for (int s = 0; s < NUM_SEG; s++)
         if (hit[s]) rdata = rdata | seg_bits[s*DW +: DW];
   end
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq #(
   parameter int NUM_COM = 4,
   localparam int PH_W   = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   output logic [PH_W-1:0] phase,
   output logic            invert
);
   localparam logic [PH_W-1:0] LAST = PH_W'(NUM_COM - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= '0;
         invert <= 1'b0;
      end else if (step) begin
         if (phase == LAST) begin
            phase  <= '0;
            invert <= ~invert;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lcd_lvl_enc.sv
module lcd_lvl_enc
   import lcd_drv_pkg::*;
#(
   parameter int NUM_COM = 4,
   parameter int NUM_SEG = 34,
   localparam int PH_W   = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
   input  logic [PH_W-1:0]            phase,
   input  logic                       invert,
   input  logic                       blank,
   input  logic [NUM_SEG*NUM_COM-1:0] seg_bits,
   output logic [NUM_COM*LVL_W-1:0]   com_lvl,
   output logic [NUM_SEG*LVL_W-1:0]   seg_lvl
);
   logic [LVL_W-1:0] sel_rail, opp_rail;

   assign sel_rail = invert ? LVL_GND : LVL_SUP;
   assign opp_rail = invert ? LVL_SUP : LVL_GND;

   for (genvar k = 0; k < NUM_COM; k++) begin : g_com
      assign com_lvl[k*LVL_W +: LVL_W] =
         blank                   ? LVL_GND :
         (phase == PH_W'(k))     ? sel_rail : LVL_MID;
   end

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      logic [NUM_COM-1:0] word;
      logic               lit;
      assign word = seg_bits[s*NUM_COM +: NUM_COM];
      assign lit  = word[phase];
      assign seg_lvl[s*LVL_W +: LVL_W] =
         blank ? LVL_GND : (lit ? opp_rail : sel_rail);
   end
endmodule

// File: rtl/lcd_scan_drv.sv
module lcd_scan_drv
   import lcd_drv_pkg::*;
#(
   parameter int NUM_COM = 4,
   parameter int NUM_SEG = 34
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [7:0]                 addr,
   input  logic [NUM_COM-1:0]         wdata,
   output logic [NUM_COM-1:0]         rdata,
   input  logic                       phase_strobe,
   input  logic                       blank,
   output logic [NUM_COM*LVL_W-1:0]   com_lvl,
   output logic [NUM_SEG*LVL_W-1:0]   seg_lvl
);
   localparam int PH_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1;

   if (NUM_COM < 2 || NUM_COM > 4) begin : g_bad_com
      $error("lcd_scan_drv: NUM_COM must lie in 2..4");
   end
   if (NUM_SEG < 1 || NUM_SEG > PAIR_SEGS + 2) begin : g_bad_seg
      $error("lcd_scan_drv: NUM_SEG must lie in 1..34");
   end

   logic [NUM_SEG*NUM_COM-1:0] seg_bits;
   logic [PH_W-1:0]            phase;
   logic                       invert;

   lcd_disp_mem #(.NUM_SEG(NUM_SEG), .DW(NUM_COM)) u_mem (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .seg_bits(seg_bits)
   );

   lcd_phase_seq #(.NUM_COM(NUM_COM)) u_seq (
      .clk(clk), .rst_n(rst_n), .step(phase_strobe),
      .phase(phase), .invert(invert)
   );

   lcd_lvl_enc #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_enc (
      .phase(phase), .invert(invert), .blank(blank), .seg_bits(seg_bits),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl)
   );
endmodule

// File: rtl/lcd_drv_chk.sv
module lcd_drv_chk #(
   parameter int NUM_COM = 4,
   parameter int NUM_SEG = 34
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [7:0]             addr,
   input logic [NUM_COM-1:0]     rdata,
   input logic                   phase_strobe,
   input logic                   blank,
   input logic [NUM_COM*2-1:0]   com_lvl,
   input logic [NUM_SEG*2-1:0]   seg_lvl
);
   logic [NUM_COM-1:0] com_act;
   logic [NUM_COM-1:0] com_bad;
   logic [NUM_SEG-1:0] seg_bad;
   logic [3:0]         pg, ix;
   logic               mapped;

   for (genvar k = 0; k < NUM_COM; k++) begin : g_c
      assign com_act[k] = (com_lvl[2*k +: 2] != 2'b01);
      assign com_bad[k] = (com_lvl[2*k +: 2] == 2'b11);
   end
   for (genvar s = 0; s < NUM_SEG; s++) begin : g_s
      assign seg_bad[s] = (seg_lvl[2*s +: 2] == 2'b11) || (seg_lvl[2*s +: 2] == 2'b01);
   end

   assign pg = addr[7:4];
   assign ix = addr[3:0];
   assign mapped = (pg == 4'h8 && 2 * int'(ix) < NUM_SEG) ||
                   (pg == 4'h9 && 2 * int'(ix) + 1 < NUM_SEG) ||
                   (pg == 4'hA && ix == 4'h0 && NUM_SEG > 32) ||
                   (pg == 4'hB && ix == 4'h0 && NUM_SEG > 33);

   // R5
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> rdata == '0);

   // R6
   one_active_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !blank |-> ($countones(com_act) == 1 && com_bad == '0));

   // R7
   seg_on_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !blank |-> seg_bad == '0);

   // R8
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!phase_strobe && !blank) |=> (blank || $stable(com_lvl)));

   // R10
   blank_ground_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blank |-> (com_lvl == '0 && seg_lvl == '0));
endmodule

bind lcd_scan_drv lcd_drv_chk #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata),
   .phase_strobe(phase_strobe), .blank(blank),
   .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/tb_lcd_scan_drv.sv
`timescale 1ns/1ps
module tb_lcd_scan_drv;
   localparam int NC = 4;
   localparam int NS = 34;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [7:0]        addr = 8'h00;
   logic [NC-1:0]     wdata = '0;
   logic [NC-1:0]     rdata;
   logic              phase_strobe = 1'b0;
   logic              blank = 1'b0;
   logic [NC*2-1:0]   com_lvl;
   logic [NS*2-1:0]   seg_lvl;

   always #2.5 clk = ~clk;

   lcd_scan_drv #(.NUM_COM(NC), .NUM_SEG(NS)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .phase_strobe(phase_strobe), .blank(blank),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl)
   );

   typedef struct {
      string           req;
      logic [NC*2-1:0] ec;
      logic [NS*2-1:0] es;
      bit              rd;
      logic [NC-1:0]   er;
   } item_t;

   item_t       q[$];
   int          n_chk = 0;
   int          n_fail = 0;
   logic [3:0]  sh[NS];
   int          m_ph = 0;
   bit          m_inv = 1'b0;
   bit          m_bl = 1'b0;

   function automatic int map_seg(logic [7:0] a);
      if (a[7:4] == 4'h8) return 2 * int'(a[3:0]);
      if (a[7:4] == 4'h9) return 2 * int'(a[3:0]) + 1;
      if (a == 8'hA0) return 32;
      if (a == 8'hB0) return 33;
      return -1;
   endfunction

   function automatic logic [NC*2-1:0] exp_com();
      logic [NC*2-1:0] v;
      for (int k = 0; k < NC; k++)
         v[2*k +: 2] = m_bl ? 2'b00 : (k == m_ph ? (m_inv ? 2'b00 : 2'b10) : 2'b01);
      return v;
   endfunction

   function automatic logic [NS*2-1:0] exp_seg();
      logic [NS*2-1:0] v;
      logic [1:0] same, other;
      same  = m_inv ? 2'b00 : 2'b10;
      other = m_inv ? 2'b10 : 2'b00;
      for (int s = 0; s < NS; s++)
         v[2*s +: 2] = m_bl ? 2'b00 : (sh[s][m_ph] ? other : same);
      return v;
   endfunction

   task automatic push(string r, bit rd);
      item_t it;
      int sg;
      it.req = r; it.ec = exp_com(); it.es = exp_seg(); it.rd = rd;
      sg = map_seg(addr);
      it.er = (sg < 0) ? 4'h0 : sh[sg];
      q.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic do_write(logic [7:0] a, logic [3:0] d);
      int sg;
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
      sg = map_seg(a);
      if (sg >= 0) sh[sg] = d;
   endtask

   task automatic do_strobe();
      phase_strobe = 1'b1;
      @(posedge clk); #1;
      phase_strobe = 1'b0;
      if (m_ph == NC - 1) begin m_ph = 0; m_inv = ~m_inv; end
      else m_ph = m_ph + 1;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // monitor
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         while (q.size() > 0) begin
            it = q.pop_front();
            n_chk++;
            if (com_lvl !== it.ec) begin
               n_fail++;
               $display("FAIL %s com_lvl actual=%h expected=%h", it.req, com_lvl, it.ec);
            end else if (seg_lvl !== it.es) begin
               n_fail++;
               $display("FAIL %s seg_lvl actual=%h expected=%h", it.req, seg_lvl, it.es);
            end else if (it.rd && rdata !== it.er) begin
               n_fail++;
               $display("FAIL %s rdata@%h actual=%h expected=%h", it.req, addr, rdata, it.er);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      for (int s = 0; s < NS; s++) sh[s] = 4'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      addr = 8'h80; push("R1", 1'b1);
      addr = 8'hB0; push("R1", 1'b1);

      // R2 R3 R4 stores
      for (int n = 0; n < 16; n++) do_write(8'(8'h80 + n), 4'((n * 7 + 3) & 15));
      for (int n = 0; n < 16; n++) do_write(8'(8'h90 + n), 4'((n * 5 + 10) & 15));
      do_write(8'hA0, 4'hC);
      do_write(8'hB0, 4'h5);
      for (int n = 0; n < 16; n++) begin addr = 8'(8'h80 + n); push("R2", 1'b1); end
      for (int n = 0; n < 16; n++) begin addr = 8'(8'h90 + n); push("R3", 1'b1); end
      addr = 8'hA0; push("R4", 1'b1);
      addr = 8'hB0; push("R4", 1'b1);
      do_write(8'h83, 4'h0);
      addr = 8'h83; push("R2", 1'b1);

      // R5 unmapped addresses
      do_write(8'hA1, 4'hF); push("R5", 1'b1);
      do_write(8'hB7, 4'hF); push("R5", 1'b1);
      do_write(8'h7F, 4'hF); push("R5", 1'b1);
      do_write(8'hC0, 4'hF); push("R5", 1'b1);
      do_write(8'h00, 4'hF); push("R5", 1'b1);
      addr = 8'hA0; push("R5", 1'b1);

      // R6 R7 R8 R9 through two full frames
      for (int i = 0; i < 2 * NC + 1; i++) begin
         do_strobe();
         push("R6 R7 R9", 1'b0);
         repeat (2) @(posedge clk);
         #1;
         push("R8", 1'b0);
      end

      // R10 blank
      blank = 1'b1; m_bl = 1'b1;
      @(posedge clk); #1;
      push("R10", 1'b0);
      do_write(8'h85, 4'hA);
      addr = 8'h85; push("R10", 1'b1);
      blank = 1'b0; m_bl = 1'b0;
      @(posedge clk); #1;
      push("R10", 1'b0);
      do_strobe();
      push("R7", 1'b0);

      repeat (2) @(negedge clk);
      summary();
      $finish;
   end
endmodule